// File: doc/BRIEF.md
# Embedded Controller Host Port

This block is the device side of a byte-wide host port. A host reaches a private array of byte registers not by direct address decode but through a paced exchange. It writes a command byte to the command/status port. It then writes one or two bytes to the data port: a register address and, for a store, the value. Read results come back through the data port. Two flags in the status byte pace every step. The input-busy flag is set while a byte the host wrote is still being taken in. The output-ready flag is set while a result byte waits for the host.

The host polls the input-busy flag clear before each write and polls the output-ready flag set before each read. Each accepted byte holds the input-busy flag for a programmable number of cycles, which models the time the controller needs to consume it. The byte takes effect when the flag drops. The block also keeps a burst-mode flag, a flag saying whether the last accepted byte was a command, and a query command that always answers zero.

Top module: `ec_host_port`

## Requirements
- R1: After reset the status byte reads 0x00, the data port reads 0x00 and every register of the array holds 0x00.
- R2: With `host_sel` high a read returns the status byte and a write is a command byte. With `host_sel` low both go to the data port.
- R3: An accepted write sets status bit 1 (input busy) from the next cycle for exactly `BUSY_CYC` cycles. The byte acts on the edge where the bit drops.
- R4: Status bit 3 is 1 when the last accepted byte was a command and 0 when it was data.
- R5: Command 0x80 followed by a data byte A places register A in the data port and sets status bit 0 (output ready).
- R6: Command 0x81 followed by data bytes A and V stores V in register A.
- R7: A data-port read strobe clears status bit 0 unless a new result is loaded in the same cycle.
- R8: Command 0x82 sets status bit 4 (burst mode) and command 0x83 clears it.
- R9: Command 0x84 places 0x00 in the data port and sets status bit 0.
- R10: Any other command value returns the block to idle. A data byte that arrives in idle has no effect on registers, status bit 0 or the data port.
- R11: A command byte that arrives while a read or write sequence is open abandons that sequence and starts the new command.
- R12: A write that arrives while status bit 1 is set is ignored and the pending byte is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_rd | input | 1 | Host read strobe |
| host_sel | input | 1 | 1 selects command/status port, 0 selects data port |
| host_wdata | input | 8 | Byte written by the host |
| host_rdata | output | 8 | Status byte or data byte, chosen by host_sel |

## Verification
The bench builds the block with `BUSY_CYC` set to 3 and `ADDR_W` at its default of 8. The busy window is therefore short enough that each flag transition is seen within a few cycles, yet longer than one cycle. This lets a second write be placed inside the window to exercise the ignore rule. With the full 8-bit address, register addresses taken straight from the data byte reach both ends of the array.

// File: rtl/ec_port_pkg.sv
package ec_port_pkg;

    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;

    localparam byte_t OP_READ      = 8'h80;
    localparam byte_t OP_WRITE     = 8'h81;
    localparam byte_t OP_BURST_ON  = 8'h82;
    localparam byte_t OP_BURST_OFF = 8'h83;
    localparam byte_t OP_QUERY     = 8'h84;

    localparam int ST_OBF   = 0;
    localparam int ST_IBF   = 1;
    localparam int ST_CMD   = 3;
    localparam int ST_BURST = 4;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_RD_ADDR,
        SQ_WR_ADDR,
        SQ_WR_DATA
    } seq_e;

    typedef struct packed {
        logic  is_cmd;
        byte_t val;
    } inbyte_t;

    function automatic byte_t pack_status(logic obf, logic ibf, logic cmd, logic burst);
        byte_t s;
        s           = '0;
        s[ST_OBF]   = obf;
        s[ST_IBF]   = ibf;
        s[ST_CMD]   = cmd;
        s[ST_BURST] = burst;
        return s;
    endfunction

endpackage

// File: rtl/ec_inbuf.sv
module ec_inbuf
    import ec_port_pkg::*;
#(
    parameter int BUSY_CYC = 4
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    wr_en,
    input  logic    wr_sel,
    input  byte_t   wr_data,
    output logic    ibf,
    output logic    consume,
    output inbyte_t held
);
    localparam int CNT_W = $clog2(BUSY_CYC + 1);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(BUSY_CYC - 1);

    logic [CNT_W-1:0] cnt;
    logic             accept;

    assign accept  = wr_en && !ibf;
    assign consume = ibf && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ibf  <= 1'b0;
            cnt  <= '0;
            held <= '0;
        end else if (accept) begin
            ibf         <= 1'b1;
            cnt         <= LOAD_VAL;
            held.is_cmd <= wr_sel;
            held.val    <= wr_data;
        end else if (ibf) begin
            if (cnt == '0) ibf <= 1'b0;
            else           cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/ec_seq.sv
module ec_seq
    import ec_port_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              consume,
    input  inbyte_t           in_byte,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output byte_t             mem_wdata,
    output logic              obf_load,
    output logic              obf_from_mem,
    output logic              burst
);
    seq_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SQ_IDLE;
            mem_waddr <= '0;
            burst     <= 1'b0;
        end else if (consume) begin
            if (in_byte.is_cmd) begin
                case (in_byte.val)
                    OP_READ:      state <= SQ_RD_ADDR;
                    OP_WRITE:     state <= SQ_WR_ADDR;
                    OP_BURST_ON:  begin burst <= 1'b1; state <= SQ_IDLE; end
                    OP_BURST_OFF: begin burst <= 1'b0; state <= SQ_IDLE; end
                    default:      state <= SQ_IDLE;
                endcase
            end else begin
                case (state)
                    SQ_WR_ADDR: begin
                        mem_waddr <= in_byte.val[ADDR_W-1:0];
                        state     <= SQ_WR_DATA;
                    end
                    default: state <= SQ_IDLE;
                endcase
            end
        end
    end

    always_comb begin
        mem_we       = consume && !in_byte.is_cmd && (state == SQ_WR_DATA);
        mem_wdata    = in_byte.val;
        obf_from_mem = !in_byte.is_cmd;
        obf_load     = consume &&
                       ((in_byte.is_cmd && (in_byte.val == OP_QUERY)) ||
                        (!in_byte.is_cmd && (state == SQ_RD_ADDR)));
    end
endmodule

// File: rtl/ec_regfile.sv
module ec_regfile
    import ec_port_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  byte_t             wdata,
    input  logic [ADDR_W-1:0] raddr,
    output byte_t             rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    byte_t regs [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
        end else if (we) begin
            regs[waddr] <= wdata;
        end
    end

    assign rdata = regs[raddr];
endmodule

// File: rtl/ec_host_port.sv
module ec_host_port
    import ec_port_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int BUSY_CYC = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       host_wr,
    input  logic       host_rd,
    input  logic       host_sel,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata
);
    logic              ibf;
    logic              consume;
    inbyte_t           held;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    byte_t             mem_wdata;
    byte_t             mem_rdata;
    logic              obf_load;
    logic              obf_from_mem;
    logic              burst;
    logic              obf;
    byte_t             out_byte;
    byte_t             status_byte;

    ec_inbuf #(.BUSY_CYC(BUSY_CYC)) u_inbuf (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (host_wr),
        .wr_sel  (host_sel),
        .wr_data (host_wdata),
        .ibf     (ibf),
        .consume (consume),
        .held    (held)
    );

    ec_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .consume      (consume),
        .in_byte      (held),
        .mem_we       (mem_we),
        .mem_waddr    (mem_waddr),
        .mem_wdata    (mem_wdata),
        .obf_load     (obf_load),
        .obf_from_mem (obf_from_mem),
        .burst        (burst)
    );

    ec_regfile #(.ADDR_W(ADDR_W)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (held.val[ADDR_W-1:0]),
        .rdata (mem_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            obf      <= 1'b0;
            out_byte <= '0;
        end else if (obf_load) begin
            obf      <= 1'b1;
            out_byte <= obf_from_mem ? mem_rdata : '0;
        end else if (host_rd && !host_sel) begin
            obf <= 1'b0;
        end
    end

    assign status_byte = pack_status(obf, ibf, held.is_cmd, burst);
    assign host_rdata  = host_sel ? status_byte : out_byte;
endmodule

// File: rtl/ec_host_port_chk.sv
module ec_host_port_chk
    import ec_port_pkg::*;
#(
    parameter int BUSY_CYC = 4
) (
    input logic  clk,
    input logic  rst,
    input logic  host_wr,
    input logic  host_rd,
    input logic  host_sel,
    input logic  ibf,
    input logic  obf,
    input logic  obf_load,
    input byte_t held_val,
    input byte_t status_byte
);
    logic [15:0] run;

    always_ff @(posedge clk) begin
        if (rst)      run <= '0;
        else if (ibf) run <= run + 1'b1;
        else          run <= '0;
    end

    p_accept_sets_ibf_r3: assert property (@(posedge clk) disable iff (rst)
        (host_wr && !ibf) |=> ibf);

    p_ibf_window_r3: assert property (@(posedge clk) disable iff (rst)
        (!ibf && $past(ibf)) |-> (run == 16'(BUSY_CYC)));

    p_busy_write_ignored_r12: assert property (@(posedge clk) disable iff (rst)
        (host_wr && ibf) |=> $stable(held_val));

    p_rd_clears_obf_r7: assert property (@(posedge clk) disable iff (rst)
        (host_rd && !host_sel && !obf_load) |=> !obf);

    p_cmd_flag_r4: assert property (@(posedge clk) disable iff (rst)
        (host_wr && !ibf && host_sel) |=> status_byte[ST_CMD]);

    p_obf_load_sets_r5: assert property (@(posedge clk) disable iff (rst)
        obf_load |=> obf);
endmodule

bind ec_host_port ec_host_port_chk #(.BUSY_CYC(BUSY_CYC)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .host_wr     (host_wr),
    .host_rd     (host_rd),
    .host_sel    (host_sel),
    .ibf         (ibf),
    .obf         (obf),
    .obf_load    (obf_load),
    .held_val    (held.val),
    .status_byte (status_byte)
);

// File: tb/ec_host_port_tb_top.sv
module ec_host_port_tb_top;
    localparam int BUSY = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic       host_sel = 1'b1;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    ec_host_port #(.ADDR_W(8), .BUSY_CYC(BUSY)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_sel   (host_sel),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata)
    );

    // behavioural reference model
    logic [7:0] m_mem [256];
    bit         m_ibf, m_obf, m_iscmd, m_burst;
    int         m_left, m_mode, m_addr;
    logic [7:0] m_byte, m_out;

    always @(posedge clk) begin
        bit         ld;
        logic [7:0] nv;
        ld = 0; nv = 8'h00;
        if (rst) begin
            foreach (m_mem[i]) m_mem[i] = 8'h00;
            m_ibf = 0; m_obf = 0; m_iscmd = 0; m_burst = 0;
            m_left = 0; m_mode = 0; m_addr = 0; m_byte = 0; m_out = 0;
        end else begin
            if (m_ibf && m_left == 1) begin
                if (m_iscmd) begin
                    m_mode = 0;
                    if (m_byte == 8'h80) m_mode = 1;
                    else if (m_byte == 8'h81) m_mode = 2;
                    else if (m_byte == 8'h82) m_burst = 1;
                    else if (m_byte == 8'h83) m_burst = 0;
                    else if (m_byte == 8'h84) begin ld = 1; nv = 8'h00; end
                end else begin
                    if (m_mode == 1) begin ld = 1; nv = m_mem[m_byte]; m_mode = 0; end
                    else if (m_mode == 2) begin m_addr = m_byte; m_mode = 3; end
                    else if (m_mode == 3) begin m_mem[m_addr] = m_byte; m_mode = 0; end
                end
            end
            if (ld) begin m_obf = 1; m_out = nv; end
            else if (host_rd && !host_sel) m_obf = 0;
            if (host_wr && !m_ibf) begin
                m_ibf = 1; m_left = BUSY; m_byte = host_wdata; m_iscmd = host_sel;
            end else if (m_ibf) begin
                if (m_left == 1) m_ibf = 0;
                else m_left--;
            end
        end
    end

    function automatic logic [7:0] model_status();
        return {3'b000, m_burst, m_iscmd, 1'b0, m_ibf, m_obf};
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // every-cycle comparison against the model (R2 R3 R4 R5 R7 R8)
    always @(negedge clk) begin
        if (!rst)
            check(host_sel ? "R2 R3 R4 R8 model status" : "R5 R7 model data",
                  host_rdata, host_sel ? model_status() : m_out);
    end

    task automatic drive_cycle();
        @(posedge clk); #2;
    endtask

    task automatic wait_ibf_clear();
        host_sel = 1'b1;
        @(negedge clk);
        while (host_rdata[1]) @(negedge clk);
    endtask

    task automatic put(bit sel, logic [7:0] b);
        wait_ibf_clear();
        drive_cycle();
        host_sel = sel; host_wdata = b; host_wr = 1'b1;
        drive_cycle();
        host_wr = 1'b0; host_sel = 1'b1;
    endtask

    task automatic get(output logic [7:0] v);
        host_sel = 1'b1;
        @(negedge clk);
        while (!host_rdata[0]) @(negedge clk);
        drive_cycle();
        host_sel = 1'b0; host_rd = 1'b1;
        @(negedge clk);
        v = host_rdata;
        drive_cycle();
        host_rd = 1'b0; host_sel = 1'b1;
    endtask

    task automatic settle();
        wait_ibf_clear();
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int n;
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;

        // R1 reset state
        @(negedge clk);
        check("R1 status after reset", host_rdata, 8'h00);
        host_sel = 1'b0;
        @(negedge clk);
        check("R1 data after reset", host_rdata, 8'h00);
        host_sel = 1'b1;

        // R3 busy window length and R4 command flag
        drive_cycle();
        host_sel = 1'b1; host_wdata = 8'h83; host_wr = 1'b1;
        drive_cycle();
        host_wr = 1'b0;
        n = 0;
        @(negedge clk);
        check("R4 command flag", {7'd0, host_rdata[3]}, 8'd1);
        while (host_rdata[1]) begin n++; @(negedge clk); end
        check("R3 busy cycles", 8'(n), 8'(BUSY));

        // R1 array cleared, R5 read command
        put(1, 8'h80); put(0, 8'hFF);
        get(v);
        check("R1 R5 reset register ff", v, 8'h00);

        // R6 write then R5 readback, R4 data flag
        put(1, 8'h81); put(0, 8'h05); put(0, 8'hC3);
        settle();
        check("R4 data flag", {7'd0, host_rdata[3]}, 8'd0);
        put(1, 8'h80); put(0, 8'h05);
        get(v);
        check("R5 R6 readback 05", v, 8'hC3);

        // R7 read strobe cleared output ready
        @(negedge clk);
        check("R7 obf cleared", {7'd0, host_rdata[0]}, 8'd0);

        // R9 query returns zero
        put(1, 8'h84);
        get(v);
        check("R9 query value", v, 8'h00);

        // R8 burst on / off
        put(1, 8'h82); settle();
        check("R8 burst set", {7'd0, host_rdata[4]}, 8'd1);
        put(1, 8'h83); settle();
        check("R8 burst clear", {7'd0, host_rdata[4]}, 8'd0);

        // R10 unknown command, idle data ignored
        put(1, 8'h55); put(0, 8'h20); put(0, 8'h77); settle();
        check("R10 no output after unknown", {7'd0, host_rdata[0]}, 8'd0);
        host_sel = 1'b0; @(negedge clk);
        check("R10 data port unchanged", host_rdata, 8'h00);
        host_sel = 1'b1;
        put(1, 8'h80); put(0, 8'h20);
        get(v);
        check("R10 register 20 untouched", v, 8'h00);
        put(1, 8'h80); put(0, 8'h77);
        get(v);
        check("R10 register 77 untouched", v, 8'h00);

        // R11 command aborts open write sequence
        put(1, 8'h81); put(0, 8'h30);
        put(1, 8'h80); put(0, 8'h30);
        get(v);
        check("R11 abort leaves 30", v, 8'h00);

        // R12 write during busy window is ignored
        drive_cycle();
        host_sel = 1'b1; host_wdata = 8'h81; host_wr = 1'b1;
        drive_cycle();
        host_wdata = 8'h80;
        drive_cycle();
        host_wr = 1'b0;
        put(0, 8'hFF); put(0, 8'h5A);
        put(1, 8'h80); put(0, 8'hFF);
        get(v);
        check("R12 busy write dropped", v, 8'h5A);

        // R2 data-port read never shows status
        host_sel = 1'b0; @(negedge clk);
        check("R2 data port value", host_rdata, 8'h5A);
        host_sel = 1'b1;

        repeat (4) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule